// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. It carries out one complete register access on a target per start strobe. It drives the debug clock and the data line, which has a separate output enable. It also samples the returning data line. A caller supplies an 8-bit request byte that already carries its own parity, a 32-bit word for writes, and a half-period setting. The engine then runs the request, the line turnaround, the three-bit acknowledge and the data phase. It returns a result code and, for reads, the received word.

Every wire bit is one slot. The clock is low for one half-period and then high for one half-period. Outgoing data changes at the start of the low half. Incoming data is registered at the instant the clock rises. The acknowledge is handled by a small decision tree. WAIT replies resend the whole request, up to a parameterised limit. Every non-OK reply first gets an extra turnaround clock. Timeout, fault and absent target each end with a distinct code.

Top module: `swd_host_xact`

## Requirements
- R1: After reset, and whenever no transaction is running, the clock output is high, the data output enable is low and busy is low.
- R2: Each bit slot holds the clock low for H system cycles and then high for H cycles. H is the half_period value captured at the start strobe, and a value of 0 is used as 1.
- R3: The request byte is sent bit 0 first with the driver enabled. The driver is then released for one turnaround slot. The data output only changes while the clock is low.
- R4: Three acknowledge bits are sampled with the driver released, first received bit as bit 0. The value 3'b001 means OK, 3'b010 means WAIT and 3'b100 means FAULT.
- R5: Any reply other than OK is followed by one extra released slot. The transaction then ends with code 52 for FAULT, or with code 5 for any pattern that is neither OK nor WAIT.
- R6: On WAIT the full request is resent, up to RETRIES extra attempts. A WAIT on the last allowed attempt ends with code 30.
- R7: Command bit 2 low selects a write. After OK, a write sends one released turnaround slot, the 32 data bits starting at bit 0, and an even-parity bit. It then drives 8 low idle slots and ends with code 0.
- R8: Command bit 2 high selects a read. After OK, a read samples 32 data bits and a parity bit with the driver released, then drives 8 low idle slots. rdata holds the received word. The code is 0 when the XOR of all 33 bits is 0, and 51 otherwise.
- R9: busy is high from the cycle after an accepted start until the cycle in which done pulses high for exactly one cycle. A start strobe raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | HALF_W | System cycles per clock half, captured at start |
| start | input | 1 | Begin a transaction when idle |
| cmd | input | 8 | Request byte, bit 0 sent first, bit 2 selects read |
| wdata | input | 32 | Word sent on writes |
| swdio_in | input | 1 | Sampled data line from target |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Driven data value |
| swdio_oe | output | 1 | Data driver enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Result code of the last transaction |
| rdata | output | 32 | Word received by the last read |

## Verification
The assertions assume that the target changes swdio_in only between clock rises. They also assume that half_period and cmd matter only in the start cycle, so nothing is checked about these inputs mid-transaction. The stimulus acts as the target. It sets swdio_in once per slot, on a falling system-clock edge well clear of the sampling rise. It presents requests only while the engine is idle, except for one deliberate strobe during busy that must be ignored. Acknowledge lists are always long enough to cover every resend the engine is allowed.

// File: rtl/swd_host_xact.sv
module swd_host_xact #(
  parameter int HALF_W  = 8,
  parameter int RETRIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_period,
  input  logic              start,
  input  logic [7:0]        cmd,
  input  logic [31:0]       wdata,
  input  logic              swdio_in,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  output logic              busy,
  output logic              done,
  output logic [7:0]        result,
  output logic [31:0]       rdata
);
  localparam int RW = $clog2(RETRIES + 1);
  localparam logic [HALF_W-1:0] ONE = 1;
  localparam logic [RW-1:0] RMAX = RW'(RETRIES);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_TRN, S_ACK, S_ATRN, S_WTRN, S_WDAT, S_WPAR, S_RDAT, S_RPAR, S_IDL8
  } st_t;

  st_t               st, nst;
  logic [4:0]        bitn, nbit;
  logic [HALF_W-1:0] cnt, hp_q;
  logic [7:0]        cmd_q, code;
  logic [31:0]       wd_q;
  logic [2:0]        ack;
  logic              rpar, fin, retry, n_oe, n_out;
  logic [RW-1:0]     r_cnt;

  wire tick = (cnt == hp_q - ONE);
  assign busy = (st != S_IDLE);

  always_comb begin
    nst = st; nbit = bitn + 5'd1; fin = 1'b0; retry = 1'b0; code = result;
    case (st)
      S_REQ:  if (bitn == 5'd7) begin nst = S_TRN; nbit = '0; end
      S_TRN:  begin nst = S_ACK; nbit = '0; end
      S_ACK:  if (bitn == 5'd2) begin
                nbit = '0;
                if (ack == 3'b001) nst = cmd_q[2] ? S_RDAT : S_WTRN;
                else nst = S_ATRN;
              end
      S_ATRN: begin
                nbit = '0;
                if (ack == 3'b010 && r_cnt < RMAX) begin nst = S_REQ; retry = 1'b1; end
                else begin
                  fin = 1'b1;
                  code = (ack == 3'b010) ? 8'd30 : (ack == 3'b100) ? 8'd52 : 8'd5;
                end
              end
      S_WTRN: begin nst = S_WDAT; nbit = '0; end
      S_WDAT: if (bitn == 5'd31) begin nst = S_WPAR; nbit = '0; end
      S_WPAR: begin nst = S_IDL8; nbit = '0; end
      S_RDAT: if (bitn == 5'd31) begin nst = S_RPAR; nbit = '0; end
      S_RPAR: begin nst = S_IDL8; nbit = '0; end
      S_IDL8: if (bitn == 5'd7) begin
                fin = 1'b1;
                code = (cmd_q[2] && ((^rdata) ^ rpar)) ? 8'd51 : 8'd0;
              end
      default: ;
    endcase
  end

  always_comb begin
    n_oe = 1'b0; n_out = swdio_out;
    case (nst)
      S_REQ:  begin n_oe = 1'b1; n_out = cmd_q[nbit[2:0]]; end
      S_WDAT: begin n_oe = 1'b1; n_out = wd_q[nbit]; end
      S_WPAR: begin n_oe = 1'b1; n_out = ^wd_q; end
      S_IDL8: begin n_oe = 1'b1; n_out = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitn <= '0; cnt <= '0; hp_q <= ONE;
      cmd_q <= '0; wd_q <= '0; ack <= '0; rpar <= 1'b0; r_cnt <= '0;
      swclk <= 1'b1; swdio_out <= 1'b0; swdio_oe <= 1'b0;
      done <= 1'b0; result <= '0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          hp_q <= (half_period == '0) ? ONE : half_period;
          cmd_q <= cmd; wd_q <= wdata; r_cnt <= '0;
          st <= S_REQ; bitn <= '0; cnt <= '0;
          swclk <= 1'b0; swdio_oe <= 1'b1; swdio_out <= cmd[0];
        end
      end else if (!tick) begin
        cnt <= cnt + ONE;
      end else begin
        cnt <= '0;
        if (!swclk) begin
          swclk <= 1'b1;
          case (st)
            S_ACK:  ack[bitn[1:0]] <= swdio_in;
            S_RDAT: rdata[bitn] <= swdio_in;
            S_RPAR: rpar <= swdio_in;
            default: ;
          endcase
        end else if (fin) begin
          st <= S_IDLE; done <= 1'b1; result <= code; swdio_oe <= 1'b0;
        end else begin
          st <= nst; bitn <= nbit; swclk <= 1'b0;
          swdio_oe <= n_oe; swdio_out <= n_out;
          if (retry) r_cnt <= r_cnt + 1'b1;
        end
      end
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swclk && !swdio_oe)); // R1
  AST_OUT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swdio_out) |-> !swclk); // R3
  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRN || st == S_ACK || st == S_ATRN) |-> !swdio_oe); // R4
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDAT || st == S_RPAR) |-> !swdio_oe); // R8
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    r_cnt <= RMAX); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == 8'd0 || result == 8'd5 || result == 8'd30 ||
              result == 8'd51 || result == 8'd52)); // R5
endmodule

// File: tb/tb_swd_host_xact.sv
module tb_swd_host_xact;
  localparam int HALF_W = 8;
  localparam int RETRIES = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, swdio_in = 1'b1;
  logic [HALF_W-1:0] half_period = 1;
  logic [7:0] cmd = '0;
  logic [31:0] wdata = '0;
  logic swclk, swdio_out, swdio_oe, busy, done;
  logic [7:0] result;
  logic [31:0] rdata;

  int checks = 0, fails = 0, exp_res = 0;
  logic [2:0] ack_list[$];
  logic [2:0] slot_q[$];

  always #5 clk = ~clk;

  swd_host_xact #(.HALF_W(HALF_W), .RETRIES(RETRIES)) dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .start(start),
    .cmd(cmd), .wdata(wdata), .swdio_in(swdio_in), .swclk(swclk),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .busy(busy), .done(done),
    .result(result), .rdata(rdata));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic add(input bit oe, input bit o, input bit i);
    slot_q.push_back({i, oe, o});
  endtask

  task automatic build(input logic [7:0] c, input logic [31:0] w,
                       input logic [31:0] rd, input bit badpar);
    slot_q.delete();
    foreach (ack_list[a]) begin
      for (int i = 0; i < 8; i++) add(1'b1, c[i], 1'b1);
      add(1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) add(1'b0, 1'b0, ack_list[a][i]);
      if (ack_list[a] == 3'b001) begin
        if (c[2]) begin
          for (int i = 0; i < 32; i++) add(1'b0, 1'b0, rd[i]);
          add(1'b0, 1'b0, (^rd) ^ badpar);
        end else begin
          add(1'b0, 1'b0, 1'b1);
          for (int i = 0; i < 32; i++) add(1'b1, w[i], 1'b1);
          add(1'b1, ^w, 1'b1);
        end
        for (int i = 0; i < 8; i++) add(1'b1, 1'b0, 1'b1);
        exp_res = (c[2] && badpar) ? 51 : 0;
        return;
      end
      add(1'b0, 1'b0, 1'b1);
      if (ack_list[a] == 3'b010 && a < RETRIES) continue;
      exp_res = (ack_list[a] == 3'b010) ? 30 : (ack_list[a] == 3'b100) ? 52 : 5;
      return;
    end
  endtask

  task automatic run(input logic [7:0] c, input logic [31:0] w, input int hp,
                     input logic [31:0] rd, input bit badpar, input string tag,
                     input bit poke);
    int h, per, tot;
    build(c, w, rd, badpar);
    h = (hp == 0) ? 1 : hp;
    per = 2 * h;
    tot = per * slot_q.size();
    @(negedge clk);
    cmd = c; wdata = w; half_period = HALF_W'(hp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmd = 8'hFF; wdata = 32'h0; half_period = 8'd7;
    for (int t = 0; t < tot; t++) begin
      logic [2:0] e;
      bit lo, ok;
      e = slot_q[t / per];
      lo = (t % per) < h;
      swdio_in = e[2];
      if (poke && t == 5) start = 1'b1;
      if (poke && t == 6) start = 1'b0;
      chk(swclk == !lo, "R2 swclk", swclk, !lo);
      ok = (swdio_oe == e[1]) && (!e[1] || swdio_out == e[0]);
      chk(ok, "R3 data line", {swdio_oe, swdio_out}, {e[1], e[0]});
      chk(busy && !done, "R9 busy/done", {busy, done}, 2'b10);
      @(negedge clk);
    end
    chk(done && !busy, "R9 done pulse", {done, busy}, 2'b10);
    chk(swclk && !swdio_oe, "R1 idle lines", {swclk, swdio_oe}, 2'b10);
    chk(result == 8'(exp_res), tag, result, exp_res);
    if (c[2] && (exp_res == 0 || exp_res == 51))
      chk(rdata == rd, "R8 rdata", rdata, rd);
    @(negedge clk);
    chk(!done && !busy, "R9 done single cycle", {done, busy}, 2'b00);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(swclk && !swdio_oe && !busy && !done && result == 0, "R1 reset state",
        {swclk, swdio_oe, busy, done}, 4'b1000);

    ack_list = '{3'b001};
    run(8'hA5, 32'h0, 1, 32'h2BA0_1477, 1'b0, "R8 read ok code", 1'b0);
    ack_list = '{3'b001};
    run(8'hA9, 32'hDEAD_BEEF, 3, 32'h0, 1'b0, "R7 write ok code", 1'b0);
    ack_list = '{3'b001};
    run(8'hB1, 32'h0000_0001, 0, 32'h0, 1'b0, "R2 zero half-period write", 1'b0);
    ack_list = '{3'b001};
    run(8'h8D, 32'h0, 2, 32'h1234_5678, 1'b1, "R8 parity error code", 1'b0);
    ack_list = '{3'b100};
    run(8'hA5, 32'h0, 1, 32'h0, 1'b0, "R5 fault code", 1'b0);
    ack_list = '{3'b111};
    run(8'hA5, 32'h0, 2, 32'h0, 1'b0, "R5 no-connection code", 1'b0);
    ack_list = '{3'b000};
    run(8'hA9, 32'h5, 1, 32'h0, 1'b0, "R4 silent ack code", 1'b0);
    ack_list = '{3'b010, 3'b010, 3'b001};
    run(8'hA5, 32'h0, 2, 32'hCAFE_F00D, 1'b0, "R6 wait then ok", 1'b1);
    ack_list = '{3'b010, 3'b010, 3'b010, 3'b010};
    run(8'hA5, 32'h0, 1, 32'h0, 1'b0, "R6 wait timeout code", 1'b0);
    ack_list = '{3'b010, 3'b001};
    run(8'hA9, 32'h8000_0000, 1, 32'h0, 1'b0, "R7 write after wait", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule